// File: doc/BRIEF.md
# Relocatable On-Chip Address Decoder

This block sits between a 16-bit CPU address bus and the on-chip memories. For every address it raises one chip-select among six targets: a 128-byte control-register bank, a 2 KB static RAM, a boot ROM, a 768-byte EEPROM, the main ROM, and the external bus. Alongside the select it gives the offset of the address inside the selected array. The decode is purely combinational, so a select follows the address in the same cycle.

Two small page registers set where the movable resources sit. The placement register holds the 4K page of the RAM and the 4K page of the register bank. The EEPROM page register holds the 4K page of the EEPROM. Both load on a write strobe and return to page 0 on reset. Static configuration inputs enable the EEPROM, switch the main ROM on or off, and pick between its two windows. A 2-bit operating-mode input decides whether a boot ROM appears and what happens to addresses that no on-chip resource claims.

If the RAM and the register bank are placed in the same page, the registers hide the bottom 128 bytes of RAM. The decoder then makes those bytes reachable through a second window at page offset $800–$87F.

Top module: `memmap_decoder`

## Requirements
- R1: After reset both page registers hold 0. The register bank then decodes at $0000–$007F, and RAM decodes at $0080–$087F.
- R2: An address in $p000–$p07F, where p is the register-bank page, selects the register bank (sel bit 0) with offset address[6:0]. This holds regardless of any other setting.
- R3: When the RAM page r differs from the register-bank page, $r000–$r7FF selects RAM (sel bit 1) with offset address[10:0].
- R4: When the RAM page equals the register-bank page p, $p080–$p7FF selects RAM with offset equal to address minus $p000 (128..2047). In addition, $p800–$p87F selects RAM with offset equal to address minus $p800 (0..127).
- R5: With cfg_ee_en high, $eD00–$eFFF selects the EEPROM (sel bit 3) with offset equal to address minus $eD00, where e is the EEPROM page. With cfg_ee_en low, the EEPROM is never selected.
- R6: The main ROM (sel bit 4) decodes at $4000–$FFFF with offset equal to address minus $4000 when cfg_rom_hi is 1. When cfg_rom_hi is 0 it decodes at $0000–$BFFF with offset equal to the address.
- R7: The main ROM is never selected when cfg_rom_on is 0 or when mode is test (2'b11).
- R8: In bootstrap mode (2'b10) only, $BE40–$BFFF selects the boot ROM (sel bit 2). Its offset is address minus $BE00.
- R9: Overlapping claims resolve in this fixed order: register bank, RAM, boot ROM, EEPROM, main ROM, external.
- R10: An unclaimed address selects external (sel bit 5) with offset equal to the address in expanded (2'b01) or test mode. In single-chip (2'b00) or bootstrap mode it selects nothing, drives unmapped high, and gives offset 0.
- R11: In every cycle, exactly one of the six sel bits or the unmapped flag is high.
- R12: map_wr loads map_wdata[7:4] as the RAM page and map_wdata[3:0] as the register-bank page at the next clock edge. ee_wr loads ee_wdata as the EEPROM page the same way. The decode uses the old pages until that edge. Page registers never change without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_wr | input | 1 | Load strobe for the RAM/register page register |
| map_wdata | input | 8 | [7:4] RAM page, [3:0] register-bank page |
| ee_wr | input | 1 | Load strobe for the EEPROM page register |
| ee_wdata | input | 4 | EEPROM page |
| cfg_ee_en | input | 1 | EEPROM present in the map |
| cfg_rom_on | input | 1 | Main ROM present in the map |
| cfg_rom_hi | input | 1 | 1: ROM at $4000–$FFFF, 0: ROM at $0000–$BFFF |
| mode | input | 2 | 00 single-chip, 01 expanded, 10 bootstrap, 11 test |
| addr | input | 16 | CPU address |
| sel | output | 6 | One-hot select: reg, RAM, boot, EEPROM, ROM, external (bit 0..5) |
| unmapped | output | 1 | No target claims the address |
| offset | output | 16 | Address minus the base of the selected region |

## Verification
The checker watches several properties on every clock edge:
- the select is one-hot together with the unmapped flag;
- the register bank always wins its own page;
- the ROM and the boot ROM appear only under their mode and configuration gates;
- unmapped never shows in the modes that own an external bus;
- the page registers follow their strobes and hold otherwise.

Some results can only be shown by the bench comparing against its own model across many page combinations. These are the exact offsets, the hidden-RAM window when pages coincide, the EEPROM placement, and the full priority order where RAM, EEPROM and ROM overlap.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

  localparam int ADDR_W  = 16;
  localparam int PAGE_W  = 4;
  localparam int LOW_W   = ADDR_W - PAGE_W;

  localparam int REG_BYTES  = 128;
  localparam int RAM_BYTES  = 2048;
  localparam int EE_START   = 'hD00;
  localparam int BOOT_BLOCK = 'hBE00;
  localparam int BOOT_FIRST = 'hBE40;
  localparam int BOOT_LAST  = 'hBFFF;
  localparam int ROM_HI_LO  = 'h4000;
  localparam int ROM_LO_HI  = 'hBFFF;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_EXPAND = 2'b01,
    MODE_BOOT   = 2'b10,
    MODE_TEST   = 2'b11
  } op_mode_e;

  localparam int NSEL     = 6;
  localparam int SEL_REG  = 0;
  localparam int SEL_RAM  = 1;
  localparam int SEL_BOOT = 2;
  localparam int SEL_EE   = 3;
  localparam int SEL_ROM  = 4;
  localparam int SEL_EXT  = 5;

  // Candidate windows, listed in priority order (lowest index wins)
  localparam int NWIN     = 6;
  localparam int WIN_REG  = 0;
  localparam int WIN_RAM  = 1;
  localparam int WIN_RAMX = 2;
  localparam int WIN_BOOT = 3;
  localparam int WIN_EE   = 4;
  localparam int WIN_ROM  = 5;

  function automatic int win_to_sel(input int w);
    case (w)
      WIN_REG:  return SEL_REG;
      WIN_RAM,
      WIN_RAMX: return SEL_RAM;
      WIN_BOOT: return SEL_BOOT;
      WIN_EE:   return SEL_EE;
      default:  return SEL_ROM;
    endcase
  endfunction

endpackage

// File: rtl/memmap_page_regs.sv
module memmap_page_regs
  import memmap_pkg::*;
#(
  parameter int PW    = PAGE_W,
  parameter int SYNC  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            map_wr,
  input  logic [2*PW-1:0] map_wdata,
  input  logic            ee_wr,
  input  logic [PW-1:0]   ee_wdata,
  output logic [PW-1:0]   ram_pg,
  output logic [PW-1:0]   reg_pg,
  output logic [PW-1:0]   ee_pg,
  output logic            wr_ok
);

  logic [SYNC-1:0] rst_sync_q;
  logic [SYNC-1:0] rst_sync_d;
  logic [PW-1:0]   ram_pg_d, reg_pg_d, ee_pg_d;
  logic            map_en, ee_en;

  // reset release is brought onto the clock before writes are honoured
  always_comb rst_sync_d = {rst_sync_q[SYNC-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= rst_sync_d;
  end

  assign wr_ok  = rst_sync_q[SYNC-1];
  assign map_en = map_wr & wr_ok;
  assign ee_en  = ee_wr  & wr_ok;

  always_comb begin
    ram_pg_d = ram_pg;
    reg_pg_d = reg_pg;
    ee_pg_d  = ee_pg;
    if (map_en) begin
      ram_pg_d = map_wdata[2*PW-1:PW];
      reg_pg_d = map_wdata[PW-1:0];
    end
    if (ee_en) ee_pg_d = ee_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_pg <= '0;
      reg_pg <= '0;
      ee_pg  <= '0;
    end else begin
      ram_pg <= ram_pg_d;
      reg_pg <= reg_pg_d;
      ee_pg  <= ee_pg_d;
    end
  end

endmodule

// File: rtl/memmap_window.sv
module memmap_window
  import memmap_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          en,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] first,
  input  logic [AW-1:0] last,
  input  logic [AW-1:0] origin,
  output logic          hit,
  output logic [AW-1:0] ofs
);

  assign hit = en && (addr >= first) && (addr <= last);
  assign ofs = addr - origin;

endmodule

// File: rtl/memmap_arbiter.sv
module memmap_arbiter
  import memmap_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int NW = NWIN,
  parameter int NS = NSEL
) (
  input  logic [NW-1:0]         hit,
  input  logic [NW-1:0][AW-1:0] win_ofs,
  input  logic                  ext_ok,
  input  logic [AW-1:0]         addr,
  output logic [NS-1:0]         sel,
  output logic                  unmapped,
  output logic [AW-1:0]         offset
);

  always_comb begin
    logic taken;
    taken    = 1'b0;
    sel      = '0;
    offset   = '0;
    unmapped = 1'b0;
    for (int w = 0; w < NW; w++) begin
      if (!taken && hit[w]) begin
        taken                = 1'b1;
        sel[win_to_sel(w)]   = 1'b1;
        offset               = win_ofs[w];
      end
    end
    if (!taken) begin
      if (ext_ok) begin
        sel[SEL_EXT] = 1'b1;
        offset       = addr;
      end else begin
        unmapped = 1'b1;
      end
    end
  end

endmodule

// File: rtl/memmap_decoder.sv
module memmap_decoder
  import memmap_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int PW = PAGE_W,
  parameter int NS = NSEL
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            map_wr,
  input  logic [2*PW-1:0] map_wdata,
  input  logic            ee_wr,
  input  logic [PW-1:0]   ee_wdata,
  input  logic            cfg_ee_en,
  input  logic            cfg_rom_on,
  input  logic            cfg_rom_hi,
  input  logic [1:0]      mode,
  input  logic [AW-1:0]   addr,
  output logic [NS-1:0]   sel,
  output logic            unmapped,
  output logic [AW-1:0]   offset
);

  localparam int LW = AW - PW;

  op_mode_e           op_mode;
  logic [PW-1:0]      ram_pg, reg_pg, ee_pg;
  logic               wr_ok;
  logic               shared_pg;
  logic [NWIN-1:0]    w_en, w_hit;
  logic [NWIN-1:0][AW-1:0] w_first, w_last, w_origin, w_ofs;

  assign op_mode = op_mode_e'(mode);

  memmap_page_regs #(.PW(PW)) u_pages (
    .clk       (clk),
    .rst_n     (rst_n),
    .map_wr    (map_wr),
    .map_wdata (map_wdata),
    .ee_wr     (ee_wr),
    .ee_wdata  (ee_wdata),
    .ram_pg    (ram_pg),
    .reg_pg    (reg_pg),
    .ee_pg     (ee_pg),
    .wr_ok     (wr_ok)
  );

  assign shared_pg = (ram_pg == reg_pg);

  // Window geometry, one entry per candidate in priority order
  always_comb begin
    w_en[WIN_REG]     = 1'b1;
    w_first[WIN_REG]  = {reg_pg, LW'(0)};
    w_last[WIN_REG]   = {reg_pg, LW'(REG_BYTES - 1)};
    w_origin[WIN_REG] = {reg_pg, LW'(0)};

    w_en[WIN_RAM]     = 1'b1;
    w_first[WIN_RAM]  = shared_pg ? {ram_pg, LW'(REG_BYTES)} : {ram_pg, LW'(0)};
    w_last[WIN_RAM]   = {ram_pg, LW'(RAM_BYTES - 1)};
    w_origin[WIN_RAM] = {ram_pg, LW'(0)};

    w_en[WIN_RAMX]     = shared_pg;
    w_first[WIN_RAMX]  = {ram_pg, LW'(RAM_BYTES)};
    w_last[WIN_RAMX]   = {ram_pg, LW'(RAM_BYTES + REG_BYTES - 1)};
    w_origin[WIN_RAMX] = {ram_pg, LW'(RAM_BYTES)};

    w_en[WIN_BOOT]     = (op_mode == MODE_BOOT);
    w_first[WIN_BOOT]  = AW'(BOOT_FIRST);
    w_last[WIN_BOOT]   = AW'(BOOT_LAST);
    w_origin[WIN_BOOT] = AW'(BOOT_BLOCK);

    w_en[WIN_EE]     = cfg_ee_en;
    w_first[WIN_EE]  = {ee_pg, LW'(EE_START)};
    w_last[WIN_EE]   = {ee_pg, {LW{1'b1}}};
    w_origin[WIN_EE] = {ee_pg, LW'(EE_START)};

    w_en[WIN_ROM]     = cfg_rom_on && (op_mode != MODE_TEST);
    w_first[WIN_ROM]  = cfg_rom_hi ? AW'(ROM_HI_LO) : '0;
    w_last[WIN_ROM]   = cfg_rom_hi ? {AW{1'b1}} : AW'(ROM_LO_HI);
    w_origin[WIN_ROM] = w_first[WIN_ROM];
  end

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    memmap_window #(.AW(AW)) u_win (
      .en     (w_en[g]),
      .addr   (addr),
      .first  (w_first[g]),
      .last   (w_last[g]),
      .origin (w_origin[g]),
      .hit    (w_hit[g]),
      .ofs    (w_ofs[g])
    );
  end

  memmap_arbiter #(.AW(AW), .NW(NWIN), .NS(NS)) u_arb (
    .hit      (w_hit),
    .win_ofs  (w_ofs),
    .ext_ok   ((op_mode == MODE_EXPAND) || (op_mode == MODE_TEST)),
    .addr     (addr),
    .sel      (sel),
    .unmapped (unmapped),
    .offset   (offset)
  );

endmodule

// File: rtl/memmap_decoder_chk.sv
module memmap_decoder_chk
  import memmap_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int PW = PAGE_W,
  parameter int NS = NSEL
) (
  input logic            clk,
  input logic            rst_n,
  input logic            map_wr,
  input logic [2*PW-1:0] map_wdata,
  input logic            ee_wr,
  input logic [PW-1:0]   ee_wdata,
  input logic            cfg_rom_on,
  input logic            cfg_rom_hi,
  input logic [1:0]      mode,
  input logic [AW-1:0]   addr,
  input logic [NS-1:0]   sel,
  input logic            unmapped,
  input logic [AW-1:0]   offset,
  input logic [PW-1:0]   ram_pg,
  input logic [PW-1:0]   reg_pg,
  input logic [PW-1:0]   ee_pg,
  input logic            wr_ok
);

  assert_one_target_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(sel) + 32'(unmapped)) == 1);

  assert_reg_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[AW-1:AW-PW] == reg_pg && addr[AW-PW-1:7] == '0) |-> sel[SEL_REG]);

  assert_rom_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_rom_on || mode == 2'b11) |-> !sel[SEL_ROM]);

  assert_rom_hi_offset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel[SEL_ROM] && cfg_rom_hi) |-> (offset == addr - AW'(ROM_HI_LO)));

  assert_boot_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sel[SEL_BOOT] |-> (mode == 2'b10 && addr >= AW'(BOOT_FIRST) && addr <= AW'(BOOT_LAST)));

  assert_unmapped_modes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |-> (mode == 2'b00 || mode == 2'b10));

  assert_map_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (map_wr && wr_ok) |=> (ram_pg == $past(map_wdata[2*PW-1:PW]) && reg_pg == $past(map_wdata[PW-1:0])));

  assert_ee_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_wr && wr_ok) |=> (ee_pg == $past(ee_wdata)));

  assert_map_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !map_wr |=> ($stable(ram_pg) && $stable(reg_pg)));

  assert_ee_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !ee_wr |=> $stable(ee_pg));

endmodule

bind memmap_decoder memmap_decoder_chk #(.AW(AW), .PW(PW), .NS(NS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .map_wr     (map_wr),
  .map_wdata  (map_wdata),
  .ee_wr      (ee_wr),
  .ee_wdata   (ee_wdata),
  .cfg_rom_on (cfg_rom_on),
  .cfg_rom_hi (cfg_rom_hi),
  .mode       (mode),
  .addr       (addr),
  .sel        (sel),
  .unmapped   (unmapped),
  .offset     (offset),
  .ram_pg     (ram_pg),
  .reg_pg     (reg_pg),
  .ee_pg      (ee_pg),
  .wr_ok      (wr_ok)
);

// File: tb/tb_memmap_decoder.sv
`timescale 1ns/1ps
module tb_memmap_decoder;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        map_wr;
  logic [7:0]  map_wdata;
  logic        ee_wr;
  logic [3:0]  ee_wdata;
  logic        cfg_ee_en, cfg_rom_on, cfg_rom_hi;
  logic [1:0]  mode;
  logic [15:0] addr;
  logic [5:0]  sel;
  logic        unmapped;
  logic [15:0] offset;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // bench's own copy of the page registers
  logic [3:0] m_ram, m_reg, m_ee;

  always #2.5 clk = ~clk;

  memmap_decoder dut (
    .clk(clk), .rst_n(rst_n), .map_wr(map_wr), .map_wdata(map_wdata),
    .ee_wr(ee_wr), .ee_wdata(ee_wdata), .cfg_ee_en(cfg_ee_en),
    .cfg_rom_on(cfg_rom_on), .cfg_rom_hi(cfg_rom_hi), .mode(mode),
    .addr(addr), .sel(sel), .unmapped(unmapped), .offset(offset)
  );

  // expected {sel, unmapped, offset} from the requirements
  function automatic logic [22:0] model(input logic [15:0] a);
    logic [11:0] lo;
    logic [3:0]  pg;
    bit          shared;
    lo = a[11:0];
    pg = a[15:12];
    shared = (m_ram == m_reg);
    if (pg == m_reg && lo < 12'h080)
      return {6'b000001, 1'b0, 16'(lo)};
    if (pg == m_ram && lo < 12'h800 && (!shared || lo >= 12'h080))
      return {6'b000010, 1'b0, 16'(lo)};
    if (shared && pg == m_ram && lo >= 12'h800 && lo < 12'h880)
      return {6'b000010, 1'b0, 16'(lo - 12'h800)};
    if (mode == 2'b10 && a >= 16'hBE40 && a <= 16'hBFFF)
      return {6'b000100, 1'b0, a - 16'hBE00};
    if (cfg_ee_en && pg == m_ee && lo >= 12'hD00)
      return {6'b001000, 1'b0, 16'(lo - 12'hD00)};
    if (cfg_rom_on && mode != 2'b11) begin
      if (cfg_rom_hi && a >= 16'h4000) return {6'b010000, 1'b0, a - 16'h4000};
      if (!cfg_rom_hi && a <= 16'hBFFF) return {6'b010000, 1'b0, a};
    end
    if (mode == 2'b01 || mode == 2'b11)
      return {6'b100000, 1'b0, a};
    return {6'b000000, 1'b1, 16'h0000};
  endfunction

  task automatic compare(input string tag);
    logic [22:0] exp;
    exp = model(addr);
    checks++;
    if ({sel, unmapped, offset} !== exp) begin
      errors++;
      $display("FAIL %s addr=%h mode=%b: actual sel=%b unm=%b ofs=%h expected sel=%b unm=%b ofs=%h",
               tag, addr, mode, sel, unmapped, offset, exp[22:17], exp[16], exp[15:0]);
    end
  endtask

  task automatic probe(input logic [15:0] a, input string tag);
    @(negedge clk);
    addr = a;
    #1;
    compare(tag);
  endtask

  task automatic write_map(input logic [7:0] d);
    @(negedge clk);
    map_wr = 1'b1; map_wdata = d;
    @(posedge clk);
    #1 map_wr = 1'b0;
    m_ram = d[7:4]; m_reg = d[3:0];
  endtask

  task automatic write_ee(input logic [3:0] d);
    @(negedge clk);
    ee_wr = 1'b1; ee_wdata = d;
    @(posedge clk);
    #1 ee_wr = 1'b0;
    m_ee = d;
  endtask

  task automatic set_cfg(input logic [1:0] md, input logic ee, input logic on, input logic hi);
    @(negedge clk);
    mode = md; cfg_ee_en = ee; cfg_rom_on = on; cfg_rom_hi = hi;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7193));
    rst_n = 1'b0; map_wr = 1'b0; map_wdata = '0; ee_wr = 1'b0; ee_wdata = '0;
    cfg_ee_en = 1'b1; cfg_rom_on = 1'b1; cfg_rom_hi = 1'b1; mode = 2'b00; addr = '0;
    m_ram = '0; m_reg = '0; m_ee = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset placement, R4 shared-page hidden window
    probe(16'h0000, "R1 reg base");
    probe(16'h007F, "R1 reg top");
    probe(16'h0080, "R1 ram start");
    probe(16'h07FF, "R4 ram main top");
    probe(16'h0800, "R4 hidden window base");
    probe(16'h087F, "R4 hidden window top");
    probe(16'h0880, "R10 unmapped single");
    probe(16'h0D00, "R5 eeprom default page");

    // R12 old mapping holds until the edge
    @(negedge clk);
    map_wr = 1'b1; map_wdata = 8'h21; addr = 16'h1000;
    #1 compare("R12 before edge");
    @(posedge clk);
    #1 map_wr = 1'b0; m_ram = 4'h2; m_reg = 4'h1;
    probe(16'h1000, "R12 after edge reg");
    probe(16'h007F, "R12 old reg page released");
    probe(16'h2000, "R3 ram base split");
    probe(16'h27FF, "R3 ram top split");
    probe(16'h2800, "R3 past ram");

    // R5 EEPROM moves and gates
    write_ee(4'h3);
    probe(16'h3D00, "R5 ee base");
    probe(16'h3FFF, "R5 ee top");
    probe(16'h3CFF, "R5 below ee");
    set_cfg(2'b01, 1'b0, 1'b1, 1'b1);
    probe(16'h3D00, "R5 ee disabled");

    // R6, R7, R10 ROM windows and externals
    probe(16'h4000, "R6 rom hi base");
    probe(16'h3FFF, "R10 external below rom");
    set_cfg(2'b01, 1'b1, 1'b1, 1'b0);
    probe(16'hBFFF, "R6 rom lo top");
    probe(16'hC000, "R10 external vectors");
    probe(16'h0500, "R6 rom lo base area");
    set_cfg(2'b11, 1'b1, 1'b1, 1'b1);
    probe(16'h8000, "R7 test mode no rom");
    set_cfg(2'b00, 1'b1, 1'b0, 1'b1);
    probe(16'h8000, "R7 rom off");

    // R8 boot ROM
    set_cfg(2'b10, 1'b1, 1'b1, 1'b1);
    probe(16'hBE40, "R8 boot first");
    probe(16'hBE3F, "R8 below boot");
    probe(16'hBFFF, "R8 boot last");
    write_ee(4'hB);
    probe(16'hBE40, "R8 boot over ee");
    probe(16'hBD00, "R9 ee over rom");

    // R9 priorities with all pages coinciding
    write_map(8'h55);
    write_ee(4'h5);
    probe(16'h5000, "R9 reg over ram");
    probe(16'h5080, "R9 ram over rom");
    probe(16'h5D00, "R9 ee over rom");
    probe(16'h5850, "R9 hidden window over rom");
    write_map(8'hF0);
    probe(16'hF800, "R3 ram top page past end");
    probe(16'hF7FF, "R3 ram page F top");

    // R11 random configurations and addresses
    for (int i = 0; i < 60; i++) begin
      write_map(8'($urandom));
      if ($urandom_range(0, 3) == 0) write_map({m_reg, m_reg});
      write_ee(4'($urandom));
      set_cfg(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      for (int k = 0; k < 30; k++) begin
        logic [15:0] a;
        case ($urandom_range(0, 3))
          0: a = {m_reg, 12'($urandom_range(0, 'hFF))};
          1: a = {m_ram, 12'($urandom_range('h780, 'h8FF))};
          2: a = {m_ee, 12'($urandom_range('hCF0, 'hFFF))};
          default: a = 16'($urandom);
        endcase
        probe(a, "R11 random");
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule